// File: doc/BRIEF.md
# Dual-Clock FIFO with Five Status Flags

This block is a first-in first-out buffer. It has a write port and a read port, each running on its own clock, with active-low enables on both. The word width is 18 bits and the depth is a power-of-two parameter. It drives five active-low status outputs. Empty and programmable almost-empty belong to the read clock. Full, programmable almost-full and half-full belong to the write clock. The almost thresholds arrive as inputs from a separate offset-register block.

Each pointer is passed to the other clock domain as a Gray code through two flip-flops. Every flag is a register that is computed from the next value of its own domain's pointer and from the synchronized pointer of the other domain. A retransmit pulse rewinds the read pointer to the first location, so the stored words can be replayed. An active-low output enable gates the registered read word onto the data output.

Top module: `dc_flag_fifo`

## Requirements
- R1: A rising write-clock edge with `wen_n` low and `full_n` high stores `din`. Stored words come out in the order they were written.
- R2: A rising read-clock edge with `ren_n` low and `empty_n` high loads the oldest unread word into the output register. The word is visible on `dout` after that edge.
- R3: A write while `full_n` is low and a read while `empty_n` is low have no effect, whatever the enables are. The output register keeps the last word that was validly read.
- R4: `empty_n` is low when the read-side count is zero. The read-side count is the writes the read side has seen minus the read pointer. A write becomes visible there on the third read-clock edge after it.
- R5: `full_n` is low when the write-side count equals DEPTH. The write-side count includes the write's own edge, and a read becomes visible there on the third write-clock edge after it.
- R6: `pae_n` is low when the read-side count is less than or equal to `ae_off`.
- R7: `paf_n` is low when the write-side count is greater than or equal to DEPTH minus `af_off`. `af_off` must be less than DEPTH.
- R8: `hf_n` is high for write-side counts up to DEPTH/2 and low for counts above DEPTH/2.
- R9: An asserted `rst_n` (low) empties the FIFO. It sets `empty_n`=0, `pae_n`=0, `full_n`=1, `paf_n`=1, `hf_n`=1 and clears the output register to 0.
- R10: While `oe_n` is high, `dout` is all zeros. While `oe_n` is low, `dout` shows the output register.
- R11: A read-clock edge with `rt` high rewinds the read pointer to location 0. Later reads replay the words from the first one written until the pointers meet, and the flags follow the new distance. This is valid only while the total writes since reset are at most DEPTH.
- R12: `rt` is honoured only when both `wen_n` and `ren_n` are high at that edge. Otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low, applied to both domains |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| rt | input | 1 | Retransmit pulse, active high, sampled on rclk |
| oe_n | input | 1 | Output enable, active low |
| din | input | DW | Write data |
| ae_off | input | AW+1 | Almost-empty threshold n |
| af_off | input | AW+1 | Almost-full threshold m |
| dout | output | DW | Read data, zero when disabled |
| empty_n | output | 1 | Low when empty (read clock) |
| pae_n | output | 1 | Low when almost empty (read clock) |
| hf_n | output | 1 | Low when more than half full (write clock) |
| paf_n | output | 1 | Low when almost full (write clock) |
| full_n | output | 1 | Low when full (write clock) |

## Verification
The two clocks are tied together, so the three-edge crossing latency is exact. A behavioural model of pointers and history can then predict every flag on every cycle.

- A write burst followed by reads separates the store path from the read path.
- Interleaved enable patterns expose pointer-update errors under simultaneous traffic.
- Overfilling and overdraining the buffer shows whether the full and empty guards block the extra accesses. Along the way, the half-full and almost thresholds are crossed in both directions, at two different offset settings.
- A retransmit that is blocked by an active write enable, followed by a valid retransmit, tells a gated rewind from an ungated one.

// File: rtl/dc_flag_fifo.sv
module dc_flag_fifo #(
  parameter int DW    = 18,
  parameter int DEPTH = 16
) (
  input  logic                        wclk,
  input  logic                        rclk,
  input  logic                        rst_n,
  input  logic                        wen_n,
  input  logic                        ren_n,
  input  logic                        rt,
  input  logic                        oe_n,
  input  logic [DW-1:0]               din,
  input  logic [$clog2(DEPTH):0]      ae_off,
  input  logic [$clog2(DEPTH):0]      af_off,
  output logic [DW-1:0]               dout,
  output logic                        empty_n,
  output logic                        pae_n,
  output logic                        hf_n,
  output logic                        paf_n,
  output logic                        full_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [CW-1:0] HALFC = CW'(DEPTH / 2);

  function automatic logic [CW-1:0] g2b(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] wptr, wgray, wq1, wq2;
  logic [CW-1:0] rptr, rgray, rq1, rq2;
  logic [DW-1:0] q;

  // write domain
  wire          wr_go   = !wen_n && full_n;
  wire [CW-1:0] wptr_nx = wptr + CW'(wr_go);
  wire [CW-1:0] wcnt_nx = wptr_nx - g2b(wq2);

  always_ff @(posedge wclk)
    if (wr_go) mem[wptr[AW-1:0]] <= din;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      wgray  <= '0;
      wq1    <= '0;
      wq2    <= '0;
      full_n <= 1'b1;
      paf_n  <= 1'b1;
      hf_n   <= 1'b1;
    end else begin
      wptr   <= wptr_nx;
      wgray  <= wptr_nx ^ (wptr_nx >> 1);
      wq1    <= rgray;
      wq2    <= wq1;
      full_n <= (wcnt_nx != FULLC);
      paf_n  <= !(wcnt_nx >= (FULLC - af_off));
      hf_n   <= !(wcnt_nx > HALFC);
    end
  end

  // read domain
  wire          rt_go   = rt && wen_n && ren_n;
  wire          rd_go   = !ren_n && empty_n;
  wire [CW-1:0] rptr_nx = rt_go ? '0 : rptr + CW'(rd_go);
  wire [CW-1:0] rcnt_nx = g2b(rq2) - rptr_nx;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr    <= '0;
      rgray   <= '0;
      rq1     <= '0;
      rq2     <= '0;
      q       <= '0;
      empty_n <= 1'b0;
      pae_n   <= 1'b0;
    end else begin
      rptr    <= rptr_nx;
      rgray   <= rptr_nx ^ (rptr_nx >> 1);
      rq1     <= wgray;
      rq2     <= rq1;
      if (rd_go) q <= mem[rptr[AW-1:0]];
      empty_n <= (rcnt_nx != '0);
      pae_n   <= !(rcnt_nx <= ae_off);
    end
  end

  assign dout = oe_n ? '0 : q;

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    (!full_n && !wen_n) |=> $stable(wptr));

  p_hold_on_empty_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n) |=> $stable(q));

  p_full_implies_half_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    (!full_n) |-> (!hf_n && !paf_n));

  p_empty_implies_pae_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n) |-> (!pae_n));

  p_rewind_r11: assert property (@(posedge rclk) disable iff (!rst_n)
    (rt && wen_n && ren_n) |=> (rptr == '0));

  p_rptr_step_r12: assert property (@(posedge rclk) disable iff (!rst_n)
    !(rt && wen_n && ren_n) |=> (rptr == $past(rptr) || rptr == $past(rptr) + CW'(1)));
endmodule

// File: tb/dc_flag_fifo_tb.sv
`timescale 1ns/1ps
module dc_flag_fifo_tb;
  localparam int DW = 18;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, wen_n = 1'b1, ren_n = 1'b1, rt = 1'b0, oe_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [CW-1:0] ae_off = CW'(3), af_off = CW'(2);
  wire  [DW-1:0] dout;
  wire  empty_n, pae_n, hf_n, paf_n, full_n;

  dc_flag_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .wen_n(wen_n), .ren_n(ren_n),
    .rt(rt), .oe_n(oe_n), .din(din), .ae_off(ae_off), .af_off(af_off),
    .dout(dout), .empty_n(empty_n), .pae_n(pae_n), .hf_n(hf_n),
    .paf_n(paf_n), .full_n(full_n));

  int checks = 0, fails = 0, val = 1;
  bit done = 1'b0;
  string phase = "R1";
  logic [DW-1:0] hist[$];
  int wr_n, wr_h1, wr_h2, wr_h3, rd_i, rd_h1, rd_h2, rd_h3;
  logic [DW-1:0] m_q;
  logic m_empty_n, m_pae_n, m_hf_n, m_paf_n, m_full_n;

  task automatic chk(string tag, string name, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (phase %s) %s actual=%h expected=%h", tag, phase, name, act, exp);
    end
  endtask

  task automatic model_reset();
    hist.delete();
    wr_n = 0; wr_h1 = 0; wr_h2 = 0; wr_h3 = 0;
    rd_i = 0; rd_h1 = 0; rd_h2 = 0; rd_h3 = 0;
    m_q = '0;
    m_empty_n = 1'b0; m_pae_n = 1'b0; m_full_n = 1'b1; m_paf_n = 1'b1; m_hf_n = 1'b1;
  endtask

  task automatic model_edge();
    bit wacc, racc, rtok;
    int wc, rc;
    wacc = !wen_n && m_full_n;
    racc = !ren_n && m_empty_n;
    rtok = rt && wen_n && ren_n;
    wr_h3 = wr_h2; wr_h2 = wr_h1; wr_h1 = wr_n;
    rd_h3 = rd_h2; rd_h2 = rd_h1; rd_h1 = rd_i;
    if (wacc) begin hist.push_back(din); wr_n++; end
    if (racc) begin m_q = hist[rd_i]; rd_i++; end
    if (rtok) rd_i = 0;
    wc = wr_n - rd_h3;
    rc = wr_h3 - rd_i;
    m_full_n  = (wc != DEPTH);
    m_paf_n   = !(wc >= DEPTH - int'(af_off));
    m_hf_n    = !(wc > DEPTH / 2);
    m_empty_n = (rc != 0);
    m_pae_n   = !(rc <= int'(ae_off));
  endtask

  task automatic compare();
    chk("R4", "empty_n", DW'(empty_n), DW'(m_empty_n));
    chk("R5", "full_n",  DW'(full_n),  DW'(m_full_n));
    chk("R6", "pae_n",   DW'(pae_n),   DW'(m_pae_n));
    chk("R7", "paf_n",   DW'(paf_n),   DW'(m_paf_n));
    chk("R8", "hf_n",    DW'(hf_n),    DW'(m_hf_n));
    chk(oe_n ? "R10" : "R2", "dout", dout, oe_n ? '0 : m_q);
  endtask

  task automatic cyc(bit w, bit r, bit t);
    wen_n = w; ren_n = r; rt = t;
    din = DW'(val * 37 + 5); val++;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wen_n = 1'b1; ren_n = 1'b1; rt = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "empty_n", DW'(empty_n), '0);
    chk("R9", "pae_n",   DW'(pae_n),   '0);
    chk("R9", "full_n",  DW'(full_n),  DW'(1));
    chk("R9", "paf_n",   DW'(paf_n),   DW'(1));
    chk("R9", "hf_n",    DW'(hf_n),    DW'(1));
    chk("R9", "dout",    dout,         '0);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    @(negedge clk);
    phase = "R9";
    do_reset();

    phase = "R1";
    repeat (5) cyc(0, 1, 0);
    repeat (5) cyc(1, 1, 0);
    repeat (3) cyc(1, 0, 0);
    repeat (3) cyc(1, 1, 0);

    phase = "R2";
    for (int i = 0; i < 40; i++) cyc(i % 3 == 0, i % 4 == 1, 0);
    repeat (4) cyc(1, 1, 0);

    phase = "R3";
    repeat (22) cyc(0, 1, 0);
    repeat (4) cyc(1, 1, 0);
    repeat (24) cyc(1, 0, 0);
    repeat (3) cyc(1, 1, 0);

    phase = "R10";
    oe_n = 1'b1;
    repeat (3) cyc(0, 1, 0);
    repeat (4) cyc(1, 1, 0);
    repeat (2) cyc(1, 0, 0);
    oe_n = 1'b0;
    repeat (2) cyc(1, 1, 0);

    phase = "R7";
    ae_off = CW'(6); af_off = CW'(5);
    repeat (16) cyc(0, 1, 0);
    repeat (4) cyc(1, 1, 0);
    repeat (16) cyc(1, 0, 0);
    repeat (4) cyc(1, 1, 0);

    phase = "R11";
    do_reset();
    repeat (6) cyc(0, 1, 0);
    repeat (4) cyc(1, 1, 0);
    repeat (4) cyc(1, 0, 0);
    repeat (4) cyc(1, 1, 0);
    phase = "R12";
    cyc(0, 1, 1);
    cyc(1, 0, 1);
    repeat (4) cyc(1, 1, 0);
    phase = "R11";
    cyc(1, 1, 1);
    repeat (4) cyc(1, 1, 0);
    repeat (9) cyc(1, 0, 0);
    repeat (3) cyc(1, 1, 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule